// File: doc/BRIEF.md
# Priority-Table Highest Pending Resolver

This block resolves which interrupt source should be serviced next, separately for the normal-interrupt (IRQ) path and the fast-interrupt (FIQ) path. Priority is set by a programmable table of 40 slots, not by source number. Each slot names one source and carries a valid flag. Slot 0 has the highest priority.

Two 40-bit vectors come from outside the block. The first gives the enabled-and-pending sources. The second marks which of those sources are routed to FIQ. The block scans the table and reports both winners at once in one packed 32-bit status word. The status word is combinational, so it follows the current input vectors in the same cycle.

Software programs the slots through a simple register port with byte addresses. The same port returns the status word as a read-only register.

Top module: `prio_resolver_top`

## Requirements
- R1: The 40 table slots are mapped at a 4-byte stride. Slots 0 to 31 sit at byte addresses 0x1C to 0x98, and slots 32 to 39 sit at 0xB0 to 0xCC. A write to a slot address is stored on the next rising clock edge and can then be read back at the same address.
- R2: A slot write keeps only bit 31 (valid) and bits 5:0 (source ID). Every other bit of the slot reads back as zero.
- R3: A slot takes part in the scan only when its valid bit is 1 and its source ID is below 40. A slot whose valid bit is 0 never produces a winner, even if the source it names is asserted.
- R4: For each of the two paths, the winner is the source named by the lowest-numbered qualifying slot whose source is asserted on that path. The IRQ winner and the FIQ winner are chosen independently of each other.
- R5: In the status word, the IRQ winner ID is in bits 21:16 and its valid flag is bit 31. The FIQ winner ID is in bits 5:0 and its valid flag is bit 15. Bits 30:22 and 14:6 always read zero.
- R6: A path with no winner reports ID 0x3F and a valid flag of 0. When neither path has a winner, the status word is 0x003F003F.
- R7: A source is FIQ-asserted when its enabled-pending bit and its FIQ-select bit are both 1. It is IRQ-asserted when its enabled-pending bit is 1 and its FIQ-select bit is 0. A source whose FIQ-select bit is 1 but whose enabled-pending bit is 0 is asserted on neither path.
- R8: The status word reads at byte address 0x18, and a write to 0x18 has no effect. Any other address that is not a slot reads as zero, and a write to it changes no slot.
- R9: Synchronous active-high reset clears every slot to zero, which makes every slot invalid.
- R10: The status word and its read value follow the input vectors and the current table contents in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Byte address for register reads and writes |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Combinational read data for reg_addr |
| src_ena_pend | input | 40 | Enabled-and-pending vector, one bit per source |
| src_fiq_sel | input | 40 | FIQ routing vector, one bit per source |
| status_word | output | 32 | Packed IRQ and FIQ winners |

## Verification
The only internal state is the slot table. A corrupted slot shows up in one of two ways: a wrong value when that slot's address is read back, or a different winner in the status word. Either shows in the same cycle that the slot and an asserted source are both present.

A fault in the scan order or in the IRQ/FIQ split shows directly in the status word as soon as two qualifying sources compete. The tests therefore build tables with several competing slots, invalid slots and mixed routing. Each expected word is worked out from the priority and packing rules.

// File: rtl/prio_pkg.sv
package prio_pkg;
    localparam int NUM_SRC   = 40;
    localparam int ID_W      = 6;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int IDX_W     = $clog2(NUM_SRC);
    localparam int LO_CNT    = 32;
    localparam int HI_CNT    = NUM_SRC - LO_CNT;

    localparam logic [ADDR_W-1:0] STATUS_ADDR = 8'h18;
    localparam logic [ADDR_W-1:0] LO_BASE     = 8'h1C;
    localparam logic [ADDR_W-1:0] HI_BASE     = 8'hB0;
    localparam logic [ADDR_W-1:0] LO_END      = LO_BASE + ADDR_W'(4 * LO_CNT);
    localparam logic [ADDR_W-1:0] HI_END      = HI_BASE + ADDR_W'(4 * HI_CNT);
    localparam logic [ID_W-1:0]   NONE_ID     = '1;

    typedef struct packed {
        logic            vld;
        logic [ID_W-1:0] id;
    } slot_t;

    typedef struct packed {
        logic            irq_vld;
        logic [8:0]      irq_pad;
        logic [ID_W-1:0] irq_id;
        logic            fiq_vld;
        logic [8:0]      fiq_pad;
        logic [ID_W-1:0] fiq_id;
    } status_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_sel_t;

    function automatic slot_sel_t decode_addr(logic [ADDR_W-1:0] a);
        slot_sel_t    r;
        logic [ADDR_W-1:0] off;
        r   = '0;
        off = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= LO_BASE && a < LO_END) begin
                off   = (a - LO_BASE) >> 2;
                r.hit = 1'b1;
                r.idx = off[IDX_W-1:0];
            end else if (a >= HI_BASE && a < HI_END) begin
                off   = (a - HI_BASE) >> 2;
                r.hit = 1'b1;
                r.idx = off[IDX_W-1:0] + IDX_W'(LO_CNT);
            end
        end
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] slot_to_word(slot_t s);
        return {s.vld, {(DATA_W - 1 - ID_W){1'b0}}, s.id};
    endfunction

    function automatic slot_t word_to_slot(logic [DATA_W-1:0] w);
        slot_t s;
        s.vld = w[DATA_W-1];
        s.id  = w[ID_W-1:0];
        return s;
    endfunction
endpackage

// File: rtl/prio_table.sv
module prio_table
    import prio_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  slot_sel_t                 wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    output slot_t [N-1:0]             slots
);
    slot_t wr_slot;
    assign wr_slot = word_to_slot(wr_data);

    for (genvar g = 0; g < N; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[g] <= '0;
            end else if (wr_en && wr_sel.hit && wr_sel.idx == IDX_W'(g)) begin
                slots[g] <= wr_slot;
            end
        end
    end
endmodule

// File: rtl/prio_scan.sv
module prio_scan
    import prio_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  slot_t [N-1:0]   slots,
    input  logic  [N-1:0]   ena_pend,
    input  logic  [N-1:0]   fiq_sel,
    output status_t         status
);
    localparam logic [ID_W-1:0] LIMIT = ID_W'(N);

    logic [N-1:0] fiq_act;
    logic [N-1:0] irq_act;
    assign fiq_act = ena_pend & fiq_sel;
    assign irq_act = ena_pend & ~fiq_sel;

    always_comb begin
        status        = '0;
        status.irq_id = NONE_ID;
        status.fiq_id = NONE_ID;
        for (int i = N - 1; i >= 0; i--) begin
            if (slots[i].vld && slots[i].id < LIMIT) begin
                if (fiq_act[slots[i].id]) begin
                    status.fiq_vld = 1'b1;
                    status.fiq_id  = slots[i].id;
                end
                if (irq_act[slots[i].id]) begin
                    status.irq_vld = 1'b1;
                    status.irq_id  = slots[i].id;
                end
            end
        end
    end
endmodule

// File: rtl/prio_resolver_top.sv
module prio_resolver_top
    import prio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr_en,
    input  logic [31:0]       reg_wr_data,
    output logic [31:0]       reg_rd_data,
    input  logic [39:0]       src_ena_pend,
    input  logic [39:0]       src_fiq_sel,
    output logic [31:0]       status_word
);
    slot_sel_t              sel;
    slot_t [NUM_SRC-1:0]    slots;
    status_t                status;

    assign sel = decode_addr(reg_addr);

    prio_table #(.N(NUM_SRC)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .wr_sel  (sel),
        .wr_data (reg_wr_data),
        .slots   (slots)
    );

    prio_scan #(.N(NUM_SRC)) u_scan (
        .slots    (slots),
        .ena_pend (src_ena_pend),
        .fiq_sel  (src_fiq_sel),
        .status   (status)
    );

    assign status_word = status;

    always_comb begin
        if (reg_addr == STATUS_ADDR) begin
            reg_rd_data = status;
        end else if (sel.hit) begin
            reg_rd_data = slot_to_word(slots[sel.idx]);
        end else begin
            reg_rd_data = '0;
        end
    end
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  reg_addr,
    input logic [31:0] reg_rd_data,
    input logic [39:0] src_ena_pend,
    input logic [39:0] src_fiq_sel,
    input logic [31:0] status_word
);
    a_r4_fiq_winner_asserted: assert property (@(posedge clk) disable iff (rst)
        status_word[15] |-> (status_word[5:0] < 6'd40 &&
                             src_ena_pend[status_word[5:0]] && src_fiq_sel[status_word[5:0]]));

    a_r4_irq_winner_asserted: assert property (@(posedge clk) disable iff (rst)
        status_word[31] |-> (status_word[21:16] < 6'd40 &&
                             src_ena_pend[status_word[21:16]] && !src_fiq_sel[status_word[21:16]]));

    a_r6_fiq_none_code: assert property (@(posedge clk) disable iff (rst)
        !status_word[15] |-> status_word[5:0] == 6'h3F);

    a_r6_irq_none_code: assert property (@(posedge clk) disable iff (rst)
        !status_word[31] |-> status_word[21:16] == 6'h3F);

    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        status_word[30:22] == 9'd0 && status_word[14:6] == 9'd0);

    a_r7_idle_inputs: assert property (@(posedge clk) disable iff (rst)
        src_ena_pend == 40'd0 |-> status_word == 32'h003F003F);

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> status_word == 32'h003F003F);

    a_r8_status_readport: assert property (@(posedge clk) disable iff (rst)
        reg_addr == 8'h18 |-> reg_rd_data == status_word);
endmodule

bind prio_resolver_top prio_resolver_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .reg_addr     (reg_addr),
    .reg_rd_data  (reg_rd_data),
    .src_ena_pend (src_ena_pend),
    .src_fiq_sel  (src_fiq_sel),
    .status_word  (status_word)
);

// File: tb/prio_resolver_top_tb.sv
module prio_resolver_top_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic [39:0] src_ena_pend;
    logic [39:0] src_fiq_sel;
    logic [31:0] status_word;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    prio_resolver_top dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_wr_en    (reg_wr_en),
        .reg_wr_data  (reg_wr_data),
        .reg_rd_data  (reg_rd_data),
        .src_ena_pend (src_ena_pend),
        .src_fiq_sel  (src_fiq_sel),
        .status_word  (status_word)
    );

    function automatic logic [39:0] bits(int a, int b);
        logic [39:0] v = '0;
        if (a >= 0) v[a] = 1'b1;
        if (b >= 0) v[b] = 1'b1;
        return v;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr    = a;
        reg_wr_data = d;
        reg_wr_en   = 1'b1;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic drive(logic [39:0] ep, logic [39:0] fs);
        @(negedge clk);
        src_ena_pend = ep;
        src_fiq_sel  = fs;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h1C, d); check("R9 slot0 after reset", d, 32'h0);
        rd(8'hCC, d); check("R9 slot39 after reset", d, 32'h0);
        drive(bits(3, 20), '0);
        check("R9/R6 invalid table gives none", status_word, 32'h003F003F);
        drive('0, '0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, d); check("R2 masked write slot0", d, 32'h8000_003F);
        wr(8'h98, 32'h8000_0011); rd(8'h98, d); check("R1 slot31", d, 32'h8000_0011);
        wr(8'hB0, 32'h7FFF_FFC5); rd(8'hB0, d); check("R2 slot32 invalid bits dropped", d, 32'h0000_0005);
        wr(8'hCC, 32'h8000_0027); rd(8'hCC, d); check("R1 slot39", d, 32'h8000_0027);
        rd(8'h98, d); check("R1 slot31 kept after other writes", d, 32'h8000_0011);
        wr(8'h1C, 32'h0); wr(8'h98, 32'h0); wr(8'hB0, 32'h0); wr(8'hCC, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(8'h9C, 32'h8000_0001); rd(8'h9C, d); check("R8 gap reads zero", d, 32'h0);
        wr(8'h1D, 32'h8000_0002); rd(8'h1D, d); check("R8 misaligned reads zero", d, 32'h0);
        rd(8'h1C, d); check("R8 misaligned write left slot0", d, 32'h0);
        wr(8'h18, 32'h8000_0003); rd(8'h18, d); check("R8 status write ignored", d, 32'h003F003F);
    endtask

    task automatic t_priority();
        logic [31:0] d;
        wr(8'h1C, 32'h8000_000A);   // slot0 -> source 10
        wr(8'h20, 32'h8000_0005);   // slot1 -> source 5
        wr(8'h24, 32'h8000_0027);   // slot2 -> source 39
        wr(8'h28, 32'h8000_002D);   // slot3 -> source 45
        wr(8'h2C, 32'h0000_0007);   // slot4 invalid, source 7
        drive(bits(5, 10), '0);
        check("R4 slot0 beats slot1 on IRQ", status_word, 32'h800A_003F);
        drive(bits(5, 10), bits(10, -1));
        check("R4 independent IRQ/FIQ winners", status_word, 32'h8005_800A);
        rd(8'h18, d); check("R8/R5 status via read port", d, 32'h8005_800A);
        drive(bits(5, 39), bits(5, 39));
        check("R4 FIQ lowest slot among two", status_word, 32'h003F_8005);
    endtask

    task automatic t_qualify();
        drive(bits(7, -1), '0);
        check("R3 invalid slot ignored", status_word, 32'h003F003F);
        drive(bits(6, -1), '0);
        check("R3 unlisted source no winner", status_word, 32'h003F003F);
        wr(8'h30, 32'h8000_0007);   // slot5 -> source 7
        drive(bits(7, -1), '0);
        check("R3 valid slot5 source 7", status_word, 32'h8007_003F);
    endtask

    task automatic t_classify();
        drive(bits(39, -1), bits(39, -1));
        check("R7 pending+fiq gives FIQ", status_word, 32'h003F_8027);
        drive('0, bits(39, 10));
        check("R7 fiq select without pending", status_word, 32'h003F003F);
        drive(bits(39, -1), '0);
        check("R7 pending without fiq gives IRQ", status_word, 32'h8027_003F);
    endtask

    task automatic t_comb();
        @(negedge clk);
        #1;
        src_ena_pend = bits(10, -1);
        src_fiq_sel  = '0;
        #0.5;
        check("R10 same-cycle update IRQ", status_word, 32'h800A_003F);
        src_fiq_sel = bits(10, -1);
        #0.5;
        check("R10 same-cycle update FIQ", status_word, 32'h003F_800A);
    endtask

    initial begin
        rst          = 1'b1;
        reg_addr     = '0;
        reg_wr_en    = 1'b0;
        reg_wr_data  = '0;
        src_ena_pend = '0;
        src_fiq_sel  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_unmapped();
        t_priority();
        t_qualify();
        t_classify();
        t_comb();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule